// File: doc/BRIEF.md
# Timebase-Bit Escalation Watchdog

This block keeps a free-running 64-bit timebase and watches one software-chosen bit of it. Every time that bit goes from 0 to 1, a small escalation state machine takes one step. The bit can rise because the timebase counted or because software loaded a new value. The first step only arms the watchdog. The second step raises a level interrupt to the core, if the interrupt is enabled. Any step taken after that fires a one-cycle reset request, whose kind comes from a reset-code field.

Software picks the timeout by choosing which bit to watch. A low-order bit gives a short period and a high-order bit gives a long one. Software services the watchdog by writing ones to the two status flags, which returns the machine to IDLE. The reset code cannot be changed once it has been set to a nonzero value, so a running watchdog cannot be turned off by software.

The escalation state is the pair {ENW, WIS}. The states are:
- IDLE = 00
- PEND = 01
- ARMED = 10
- FIRED = 11

On a watch event the transitions are:
- IDLE goes to ARMED (arm).
- ARMED goes to FIRED (interrupt).
- PEND goes to FIRED (re-arm).
- FIRED stays in FIRED and requests a reset (bite).

A status write clears flags and so can move the machine toward IDLE (service).

Top module: `tbwd_top`

## Requirements
- R1: The timebase increments by one on each clock with `tb_tick` high. When `tb_we` is high, `tb_wdata` is loaded instead, even if `tb_tick` is also high. Either result is visible on `tb_value` after that edge.
- R2: The 6-bit watch select is {ctl[21:18], ctl[31:30]}. Select index 0 watches timebase bit 63 (the MSB) and index 63 watches bit 0 (the LSB). Bits other than the selected one cause no event.
- R3: Exactly one watch event occurs for each 0-to-1 transition of the watched bit, whether the transition comes from counting or from a load. A falling bit causes no event. An event in IDLE moves the machine to ARMED, so status reads ENW=1 and WIS=0.
- R4: An event in ARMED moves the machine to FIRED (WIS set). An event in PEND moves it to FIRED (ENW set). Neither of these events requests a reset.
- R5: `wd_irq` is high exactly while WIS is set and the interrupt-enable bit ctl[27] is set. It follows changes to ctl[27] on the next cycle.
- R6: An event in FIRED with a nonzero reset code pulses `wd_rst_pulse` for exactly one cycle, and `wd_rst_kind` carries the code during that cycle. Code 2'b10 denotes a chip-level reset. With code 2'b00 no pulse occurs.
- R7: The reset code ctl[29:28] is sticky. Once it is nonzero, control writes leave it unchanged until `rst_n` is asserted.
- R8: The status register has ENW at bit 31 and WIS at bit 30. Both are write-one-to-clear, and writing 0 has no effect. A clear and an event in the same cycle act in order: the clear is applied first, then the event.
- R9: After reset, the timebase, the control fields and the status flags are all zero, and `wd_irq` and `wd_rst_pulse` are low.
- R10: The control read-back places the fields as follows: select low bits at 31:30, reset code at 29:28, interrupt enable at 27, select extension at 21:18. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Timebase count enable |
| tb_we | input | 1 | Timebase load strobe |
| tb_wdata | input | 64 | Timebase load value |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status write data (ones clear flags) |
| tb_value | output | 64 | Current timebase |
| ctl_value | output | 32 | Control register read-back |
| sts_value | output | 32 | Status register read-back |
| wd_irq | output | 1 | Watchdog interrupt level |
| wd_rst_pulse | output | 1 | One-cycle reset request |
| wd_rst_kind | output | 2 | Reset code that accompanies the pulse |

## Verification
The bench targets five corner cases.
- A load and a count in the same cycle: a design that lets the count win, or that sees two edges, would land in the wrong timebase value or escalate twice.
- A status clear that meets an event in the same cycle: clearing after the event would leave the machine in PEND instead of ARMED.
- The PEND path: a machine that ignores it would skip straight to a reset request.
- The two ends of the bit numbering and a mid-range select: a reversed index would watch the wrong bit and miss the event.
- Attempts to rewrite a nonzero reset code, and a bite with a zero code: a weak sticky rule or a missing zero check would change the reset outcome.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;
    localparam int TB_W      = 64;
    localparam int SEL_W     = $clog2(TB_W);
    localparam int REG_W     = 32;
    localparam int RC_W      = 2;
    // control field placement (decoded by software)
    localparam int SEL_LO_HI = 31;
    localparam int SEL_LO_LO = 30;
    localparam int RC_HI     = 29;
    localparam int RC_LO     = 28;
    localparam int IE_BIT    = 27;
    localparam int SEL_EX_HI = 21;
    localparam int SEL_EX_LO = 18;
    // status flag placement
    localparam int ENW_BIT   = 31;
    localparam int WIS_BIT   = 30;

    // encoding equals {ENW, WIS}
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_PEND  = 2'b01,
        ST_ARMED = 2'b10,
        ST_FIRED = 2'b11
    } esc_state_t;
endpackage

// File: rtl/tbwd_timebase.sv
module tbwd_timebase #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (ld)   q <= ld_val;
        else if (tick) q <= q + W'(1);
    end
endmodule

// File: rtl/tbwd_ctlreg.sv
module tbwd_ctlreg
    import tbwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [SEL_W-1:0] sel,
    output logic             ie,
    output logic [RC_W-1:0]  rc,
    output logic [REG_W-1:0] rdata
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[26:22], wdata[17:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            ie  <= 1'b0;
            rc  <= '0;
        end else if (we) begin
            sel <= {wdata[SEL_EX_HI:SEL_EX_LO], wdata[SEL_LO_HI:SEL_LO_LO]};
            ie  <= wdata[IE_BIT];
            if (rc == '0) rc <= wdata[RC_HI:RC_LO];
        end
    end

    always_comb begin
        rdata                        = '0;
        rdata[SEL_LO_HI:SEL_LO_LO]   = sel[1:0];
        rdata[RC_HI:RC_LO]           = rc;
        rdata[IE_BIT]                = ie;
        rdata[SEL_EX_HI:SEL_EX_LO]   = sel[SEL_W-1:2];
    end
endmodule

// File: rtl/tbwd_bitwatch.sv
module tbwd_bitwatch #(
    parameter int W     = 64,
    parameter int SEL_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     tb,
    input  logic [SEL_W-1:0] sel,
    output logic             evt
);
    logic [SEL_W-1:0] idx;
    logic             cur;
    logic             prev;

    assign idx = SEL_W'(W - 1) - sel;   // index 0 names the MSB
    assign cur = tb[idx];
    assign evt = cur & ~prev;

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= cur;
    end
endmodule

// File: rtl/tbwd_fsm.sv
module tbwd_fsm
    import tbwd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt,
    input  logic            clr_en,
    input  logic [1:0]      clr_bits,
    input  logic            ie,
    input  logic [RC_W-1:0] rc,
    output logic            enw,
    output logic            wis,
    output logic            irq,
    output logic            rst_pulse,
    output logic [RC_W-1:0] rst_kind
);
    esc_state_t state_q, state_n, cleared;
    logic       bite;

    always_comb begin
        cleared = esc_state_t'(state_q & ~(clr_en ? clr_bits : 2'b00));
        state_n = cleared;
        bite    = 1'b0;
        if (evt) begin
            unique case (cleared)
                ST_IDLE:  state_n = ST_ARMED;
                ST_PEND:  state_n = ST_FIRED;
                ST_ARMED: state_n = ST_FIRED;
                ST_FIRED: begin
                    state_n = ST_FIRED;
                    bite    = (rc != '0);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pulse <= 1'b0;
            rst_kind  <= '0;
        end else begin
            rst_pulse <= bite;
            rst_kind  <= bite ? rc : '0;
        end
    end

    assign enw = state_q[1];
    assign wis = state_q[0];
    assign irq = wis & ie;
endmodule

// File: rtl/tbwd_top.sv
module tbwd_top
    import tbwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tb_tick,
    input  logic        tb_we,
    input  logic [63:0] tb_wdata,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    input  logic        sts_we,
    input  logic [31:0] sts_wdata,
    output logic [63:0] tb_value,
    output logic [31:0] ctl_value,
    output logic [31:0] sts_value,
    output logic        wd_irq,
    output logic        wd_rst_pulse,
    output logic [1:0]  wd_rst_kind
);
    logic [SEL_W-1:0] sel;
    logic             ie;
    logic [RC_W-1:0]  rc;
    logic             evt;
    logic             enw;
    logic             wis;
    logic             unused_sts;

    assign unused_sts = ^sts_wdata[29:0];

    tbwd_timebase #(.W(TB_W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tb_tick),
        .ld     (tb_we),
        .ld_val (tb_wdata),
        .q      (tb_value)
    );

    tbwd_ctlreg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .sel   (sel),
        .ie    (ie),
        .rc    (rc),
        .rdata (ctl_value)
    );

    tbwd_bitwatch #(.W(TB_W), .SEL_W(SEL_W)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .tb    (tb_value),
        .sel   (sel),
        .evt   (evt)
    );

    tbwd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .clr_en    (sts_we),
        .clr_bits  ({sts_wdata[ENW_BIT], sts_wdata[WIS_BIT]}),
        .ie        (ie),
        .rc        (rc),
        .enw       (enw),
        .wis       (wis),
        .irq       (wd_irq),
        .rst_pulse (wd_rst_pulse),
        .rst_kind  (wd_rst_kind)
    );

    always_comb begin
        sts_value          = '0;
        sts_value[ENW_BIT] = enw;
        sts_value[WIS_BIT] = wis;
    end
endmodule

// File: rtl/tbwd_chk.sv
module tbwd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctl_value,
    input logic [31:0] sts_value,
    input logic        wd_irq,
    input logic        wd_rst_pulse,
    input logic [1:0]  wd_rst_kind
);
    assert_irq_needs_wis_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> (sts_value[30] && ctl_value[27]));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_pulse |=> !wd_rst_pulse);

    assert_pulse_from_fired_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_pulse |-> ($past(sts_value[31:30]) == 2'b11));

    assert_pulse_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_pulse |-> (wd_rst_kind != 2'b00 && wd_rst_kind == ctl_value[29:28]));

    assert_code_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_value[29:28]) != 2'b00) |-> (ctl_value[29:28] == $past(ctl_value[29:28])));

    assert_wis_after_enw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_value[30]) |-> $past(sts_value[31]));
endmodule

bind tbwd_top tbwd_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_value    (ctl_value),
    .sts_value    (sts_value),
    .wd_irq       (wd_irq),
    .wd_rst_pulse (wd_rst_pulse),
    .wd_rst_kind  (wd_rst_kind)
);

// File: tb/tbwd_top_test.sv
`timescale 1ns/1ps
module tbwd_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_tick = 1'b0;
    logic        tb_we = 1'b0;
    logic [63:0] tb_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        sts_we = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic [63:0] tb_value;
    logic [31:0] ctl_value;
    logic [31:0] sts_value;
    logic        wd_irq;
    logic        wd_rst_pulse;
    logic [1:0]  wd_rst_kind;

    always #2.5 clk = ~clk;

    tbwd_top uut (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .tb_we(tb_we),
        .tb_wdata(tb_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .tb_value(tb_value),
        .ctl_value(ctl_value), .sts_value(sts_value), .wd_irq(wd_irq),
        .wd_rst_pulse(wd_rst_pulse), .wd_rst_kind(wd_rst_kind)
    );

    typedef enum int {W_TB, W_CTL, W_STS, W_IRQ, W_RST, W_KIND} what_t;
    typedef struct {
        string       req;
        what_t       what;
        logic [63:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    localparam logic [63:0] MSB = 64'h8000_0000_0000_0000;
    localparam logic [31:0] S_ENW = 32'h8000_0000;
    localparam logic [31:0] S_WIS = 32'h4000_0000;
    localparam logic [31:0] S_BOTH = 32'hC000_0000;

    task automatic expect_(input string r, input what_t w, input logic [63:0] e);
        item_t it;
        it.req = r; it.what = w; it.exp = e;
        q.push_back(it);
        -> chk_ev;
    endtask

    function automatic logic [63:0] observe(what_t w);
        case (w)
            W_TB:   return tb_value;
            W_CTL:  return {32'h0, ctl_value};
            W_STS:  return {32'h0, sts_value};
            W_IRQ:  return {63'h0, wd_irq};
            W_RST:  return {63'h0, wd_rst_pulse};
            default: return {62'h0, wd_rst_kind};
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [63:0] got;
                it = q.pop_front();
                got = observe(it.what);
                n_vec++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s (%s): got %h expected %h", it.req, it.what.name(), got, it.exp);
                end
            end
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask
    task automatic wr_tb(input logic [63:0] v);
        tb_we = 1'b1; tb_wdata = v; cyc(); tb_we = 1'b0;
    endtask
    task automatic wr_ctl(input logic [31:0] v);
        ctl_we = 1'b1; ctl_wdata = v; cyc(); ctl_we = 1'b0;
    endtask
    task automatic wr_sts(input logic [31:0] v);
        sts_we = 1'b1; sts_wdata = v; cyc(); sts_we = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        // R9 reset state
        expect_("R9", W_TB, 64'h0);
        expect_("R9", W_CTL, 64'h0);
        expect_("R9", W_STS, 64'h0);
        expect_("R9", W_IRQ, 64'h0);
        expect_("R9", W_RST, 64'h0);

        // R1 counting and loading
        tb_tick = 1'b1; cyc(5); tb_tick = 1'b0;
        expect_("R1", W_TB, 64'd5);
        wr_tb(64'd4);
        expect_("R1", W_TB, 64'd4);

        // R10 / R2: select 63 (LSB), ie=1, code=2 (chip reset), junk in unused bits
        wr_ctl(32'hE83C_0000 | 32'h0000_0F0F);
        expect_("R10", W_CTL, 64'hE83C_0000);
        expect_("R2", W_STS, 64'h0);

        // R3 event caused by a load
        wr_tb(64'd5); cyc();
        expect_("R3", W_STS, {32'h0, S_ENW});
        expect_("R3", W_IRQ, 64'h0);
        expect_("R3", W_RST, 64'h0);
        // R3 falling bit gives no event
        wr_tb(64'd6); cyc();
        expect_("R3", W_STS, {32'h0, S_ENW});

        // R4 event by counting: ARMED -> FIRED
        tb_tick = 1'b1; cyc(); tb_tick = 1'b0; cyc();
        expect_("R1", W_TB, 64'd7);
        expect_("R4", W_STS, {32'h0, S_BOTH});
        expect_("R5", W_IRQ, 64'h1);
        expect_("R4", W_RST, 64'h0);

        // R5 interrupt gating by enable
        wr_ctl(32'hE03C_0000);
        expect_("R5", W_IRQ, 64'h0);
        expect_("R10", W_CTL, 64'hE03C_0000);
        wr_ctl(32'hE83C_0000);
        expect_("R5", W_IRQ, 64'h1);

        // R6 bite from FIRED
        wr_tb(64'd6); wr_tb(64'd7);
        expect_("R6", W_RST, 64'h0);
        cyc();
        expect_("R6", W_RST, 64'h1);
        expect_("R6", W_KIND, 64'h2);
        expect_("R6", W_STS, {32'h0, S_BOTH});
        cyc();
        expect_("R6", W_RST, 64'h0);

        // R7 sticky reset code
        wr_ctl(32'hC83C_0000);
        expect_("R7", W_CTL, 64'hE83C_0000);
        wr_ctl(32'hD83C_0000);
        expect_("R7", W_CTL, 64'hE83C_0000);

        // R8 write-one-to-clear
        wr_sts(S_WIS);
        expect_("R8", W_STS, {32'h0, S_ENW});
        expect_("R5", W_IRQ, 64'h0);
        wr_sts(32'h3FFF_FFFF);
        expect_("R8", W_STS, {32'h0, S_ENW});
        wr_sts(S_BOTH);
        expect_("R8", W_STS, 64'h0);

        // R4 PEND path
        wr_tb(64'd6); wr_tb(64'd7); cyc();
        wr_tb(64'd6); wr_tb(64'd7); cyc();
        expect_("R4", W_STS, {32'h0, S_BOTH});
        wr_sts(S_ENW);
        expect_("R4", W_STS, {32'h0, S_WIS});
        expect_("R5", W_IRQ, 64'h1);
        wr_tb(64'd6); wr_tb(64'd7); cyc();
        expect_("R4", W_STS, {32'h0, S_BOTH});
        expect_("R4", W_RST, 64'h0);
        wr_sts(S_BOTH);

        // R1 / R3 load and count in the same cycle
        wr_tb(64'd6);
        tb_we = 1'b1; tb_wdata = 64'd9; tb_tick = 1'b1;
        cyc();
        tb_we = 1'b0; tb_tick = 1'b0;
        expect_("R1", W_TB, 64'd9);
        cyc();
        expect_("R3", W_STS, {32'h0, S_ENW});
        cyc(3);
        expect_("R3", W_STS, {32'h0, S_ENW});

        // R8 clear meets event in the same cycle
        wr_tb(64'd10);
        tb_we = 1'b1; tb_wdata = 64'd11; cyc(); tb_we = 1'b0;
        sts_we = 1'b1; sts_wdata = S_ENW; cyc(); sts_we = 1'b0;
        expect_("R8", W_STS, {32'h0, S_ENW});

        // second run after reset
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc();
        expect_("R9", W_CTL, 64'h0);
        expect_("R9", W_STS, 64'h0);

        // R2 select 0 watches MSB; R6 code zero gives no pulse
        wr_ctl(32'h0800_0000);
        wr_tb(MSB); cyc();
        expect_("R2", W_STS, {32'h0, S_ENW});
        wr_tb(64'h0); wr_tb(MSB); cyc();
        expect_("R4", W_STS, {32'h0, S_BOTH});
        expect_("R5", W_IRQ, 64'h1);
        wr_tb(64'h0); wr_tb(MSB); cyc();
        expect_("R6", W_RST, 64'h0);
        expect_("R6", W_STS, {32'h0, S_BOTH});

        // R2 mid-range select 60 watches bit 3
        wr_sts(S_BOTH);
        wr_ctl(32'h083C_0000);
        wr_tb(64'h4); cyc();
        expect_("R2", W_STS, 64'h0);
        wr_tb(64'h8); cyc();
        expect_("R2", W_STS, {32'h0, S_ENW});

        cyc();
        done = 1'b1;
        report();
    end
endmodule